// File: doc/BRIEF.md
# Packet Capture Filter Controller

This block sits between a packet decoder for a full-speed serial bus and a byte-oriented debug channel. For each decoded packet it decides whether the packet is passed on to the debug output. It also caps how many output lines a capture run may produce.

Single-character commands arrive on a byte input. They flip a filter for each of the four packet classes (token, start-of-frame, data, setup) and flip a global filter switch. They also step a 4-bit capture limit up or down, with wrap-around, and re-arm a capture that has stopped. The limit is counted in steps of 32 lines, and a limit of zero means capture never stops. The filter switches, the limit, the last command byte and the stopped flag are driven on status outputs so that a display can show them.

Top module: `pkt_capture_filter`

## Requirements
- R1: After reset, every class filter is off and global filtering is on. The limit is 0, the last-command status is 0x00, capture is not stopped and no packet is forwarded.
- R2: A command byte 0x31, 0x32, 0x33 or 0x34 toggles the filter bit of class code 0 (token), 1 (start-of-frame), 2 (data) or 3 (setup). The bit index equals the class code. The change is visible one cycle after the command.
- R3: The space byte 0x20 inverts the global filter switch, one cycle after the command.
- R4: A packet offered with pktValid is forwarded when capture is not stopped and either global filtering is off or its class filter bit is 0. A forwarded packet raises fwdValid for one cycle on the next cycle, with fwdClass equal to the offered class.
- R5: Byte 0x37 raises the limit by one and wraps from 15 to 0. Byte 0x38 lowers it by one and wraps from 0 to 15.
- R6: Each forwarded packet advances a line count. When the limit is nonzero and the count is at least limit×32, captureStopped is high and no packet is forwarded.
- R7: Byte 0x36 clears the line count, which releases a stopped capture. If 0x36 and a forwarded packet fall in the same cycle, the count ends at zero.
- R8: While the limit is 0, captureStopped stays low whatever the count.
- R9: Every command byte is copied to lastCmd. Any byte other than the commands above changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdByte | input | 8 | Command character |
| pktValid | input | 1 | A decoded packet is offered |
| pktClass | input | 2 | Class of the offered packet (0 token, 1 SOF, 2 data, 3 setup) |
| fwdValid | output | 1 | Offered packet is forwarded (one cycle later) |
| fwdClass | output | 2 | Class of the forwarded packet |
| filtEn | output | 4 | Per-class filter bits, index = class code |
| globalOn | output | 1 | Global filtering switch |
| limit | output | 4 | Capture limit in 32-line steps |
| lastCmd | output | 8 | Most recent command byte |
| captureStopped | output | 1 | Line limit reached, capture halted |

## Verification
Some properties can be judged from one cycle and the one before it, and the assertions check these on every cycle. They cover the one-cycle effect of each command on the filter bits, the global switch, the limit and the last-command status. They also check that nothing is forwarded while stopped, that a forward only ever follows an offered packet, and that a zero limit never shows a stop. Other behaviour depends on a long count that no single-cycle property can follow: stopping after exactly limit×32 forwards, the release by re-arm, and the wrap of the limit over many steps. Only the bench's reference model, run over long random and directed sequences, can show these.

// File: rtl/capfilt_pkg.sv
package capfilt_pkg;
  localparam int CLASS_N   = 4;
  localparam int CLASS_W   = $clog2(CLASS_N);
  localparam int LIMIT_W   = 4;
  localparam int STEP_LOG2 = 5;
  localparam int CNT_W     = LIMIT_W + STEP_LOG2;

  localparam logic [7:0] CMD_CLASS_BASE = 8'h31;
  localparam logic [7:0] CMD_GLOBAL     = 8'h20;
  localparam logic [7:0] CMD_REARM      = 8'h36;
  localparam logic [7:0] CMD_LIM_UP     = 8'h37;
  localparam logic [7:0] CMD_LIM_DOWN   = 8'h38;

  typedef struct packed {
    logic [CLASS_N-1:0] toggleClass;
    logic               toggleGlobal;
    logic               rearm;
    logic               limitUp;
    logic               limitDown;
    logic               cmdSeen;
  } ctrlStrobes_t;
endpackage

// File: rtl/capfilt_ctrl.sv
module capfilt_ctrl
  import capfilt_pkg::*;
(
  input  logic         cmdValid,
  input  logic [7:0]   cmdByte,
  output ctrlStrobes_t strobes
);
  logic [CLASS_N-1:0] classHit;

  for (genvar i = 0; i < CLASS_N; i++) begin : g_class
    assign classHit[i] = cmdValid && (cmdByte == 8'(CMD_CLASS_BASE + i));
  end

  always_comb begin
    strobes              = '0;
    strobes.cmdSeen      = cmdValid;
    strobes.toggleClass  = classHit;
    strobes.toggleGlobal = cmdValid && (cmdByte == CMD_GLOBAL);
    strobes.rearm        = cmdValid && (cmdByte == CMD_REARM);
    strobes.limitUp      = cmdValid && (cmdByte == CMD_LIM_UP);
    strobes.limitDown    = cmdValid && (cmdByte == CMD_LIM_DOWN);
  end
endmodule

// File: rtl/capfilt_datapath.sv
module capfilt_datapath
  import capfilt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrlStrobes_t       strobes,
  input  logic [7:0]         cmdByte,
  input  logic               pktValid,
  input  logic [CLASS_W-1:0] pktClass,
  output logic               fwdValid,
  output logic [CLASS_W-1:0] fwdClass,
  output logic [CLASS_N-1:0] filtEn,
  output logic               globalOn,
  output logic [LIMIT_W-1:0] limit,
  output logic [7:0]         lastCmd,
  output logic               captureStopped
);
  logic [CNT_W-1:0] lineCount;
  logic [CNT_W-1:0] threshold;
  logic             passNow;

  assign threshold      = {limit, {STEP_LOG2{1'b0}}};
  assign captureStopped = (limit != '0) && (lineCount >= threshold);
  assign passNow        = pktValid && !captureStopped &&
                          (!globalOn || !filtEn[pktClass]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filtEn   <= '0;
      globalOn <= 1'b1;
      limit    <= '0;
      lastCmd  <= '0;
    end else begin
      filtEn <= filtEn ^ strobes.toggleClass;
      if (strobes.toggleGlobal) globalOn <= !globalOn;
      if (strobes.limitUp)      limit <= limit + 1'b1;
      else if (strobes.limitDown) limit <= limit - 1'b1;
      if (strobes.cmdSeen)      lastCmd <= cmdByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lineCount <= '0;
      fwdValid  <= 1'b0;
      fwdClass  <= '0;
    end else begin
      fwdValid <= passNow;
      if (passNow) fwdClass <= pktClass;
      if (strobes.rearm)  lineCount <= '0;
      else if (passNow)   lineCount <= lineCount + 1'b1;
    end
  end
endmodule

// File: rtl/pkt_capture_filter.sv
module pkt_capture_filter
  import capfilt_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmdValid,
  input  logic [7:0]   cmdByte,
  input  logic         pktValid,
  input  logic [1:0]   pktClass,
  output logic         fwdValid,
  output logic [1:0]   fwdClass,
  output logic [3:0]   filtEn,
  output logic         globalOn,
  output logic [3:0]   limit,
  output logic [7:0]   lastCmd,
  output logic         captureStopped
);
  ctrlStrobes_t strobes;

  capfilt_ctrl ctrl_i (
    .cmdValid (cmdValid),
    .cmdByte  (cmdByte),
    .strobes  (strobes)
  );

  capfilt_datapath dp_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobes        (strobes),
    .cmdByte        (cmdByte),
    .pktValid       (pktValid),
    .pktClass       (pktClass),
    .fwdValid       (fwdValid),
    .fwdClass       (fwdClass),
    .filtEn         (filtEn),
    .globalOn       (globalOn),
    .limit          (limit),
    .lastCmd        (lastCmd),
    .captureStopped (captureStopped)
  );
endmodule

// File: rtl/capfilt_checker.sv
module capfilt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmdValid,
  input logic [7:0] cmdByte,
  input logic       pktValid,
  input logic       fwdValid,
  input logic [3:0] filtEn,
  input logic       globalOn,
  input logic [3:0] limit,
  input logic [7:0] lastCmd,
  input logic       captureStopped
);
  logic classCmd;
  assign classCmd = cmdValid && (cmdByte >= 8'h31) && (cmdByte <= 8'h34);

  assert_class_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    classCmd |=> $countones(filtEn ^ $past(filtEn)) == 1);

  assert_no_stray_filter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !classCmd |=> $stable(filtEn));

  assert_global_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdByte == 8'h20) |=> globalOn != $past(globalOn));

  assert_limit_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdByte == 8'h37) |=> limit == 4'($past(limit) + 4'd1));

  assert_limit_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdByte == 8'h38) |=> limit == 4'($past(limit) - 4'd1));

  assert_fwd_needs_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pktValid |=> !fwdValid);

  assert_stop_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    captureStopped |=> !fwdValid);

  assert_zero_limit_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == 4'd0) |-> !captureStopped);

  assert_last_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid |=> lastCmd == $past(cmdByte));
endmodule

bind pkt_capture_filter capfilt_checker chk_i (.*);

// File: tb/pkt_capture_filter_tb.sv
`timescale 1ns/1ps
module pkt_capture_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdByte = 8'h00;
  logic pktValid = 1'b0;
  logic [1:0] pktClass = 2'd0;
  logic fwdValid;
  logic [1:0] fwdClass;
  logic [3:0] filtEn;
  logic globalOn;
  logic [3:0] limit;
  logic [7:0] lastCmd;
  logic captureStopped;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model
  logic [3:0] mFilt;
  logic       mGlob;
  logic [3:0] mLim;
  logic [7:0] mLast;
  logic [8:0] mCnt;
  logic       mFwd;
  logic [1:0] mFwdClass;

  always #4 clk = ~clk;

  pkt_capture_filter dut_i (.*);

  function automatic logic modelStopped(logic [3:0] lim, logic [8:0] cnt);
    return (lim != 4'd0) && (cnt >= {lim, 5'd0});
  endfunction

  function automatic logic modelPass(logic pv, logic [1:0] pc, logic [3:0] f,
                                     logic g, logic stop);
    return pv && !stop && (!g || !f[pc]);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    mFilt = 4'd0; mGlob = 1'b1; mLim = 4'd0; mLast = 8'h00;
    mCnt = 9'd0; mFwd = 1'b0; mFwdClass = 2'd0;
  endtask

  task automatic compareAll(input string tag);
    check(fwdValid == mFwd, {tag, " fwdValid R4"}, fwdValid, mFwd);
    if (mFwd) check(fwdClass == mFwdClass, {tag, " fwdClass R4"}, fwdClass, mFwdClass);
    check(filtEn == mFilt, {tag, " filtEn R2"}, filtEn, mFilt);
    check(globalOn == mGlob, {tag, " globalOn R3"}, globalOn, mGlob);
    check(limit == mLim, {tag, " limit R5"}, limit, mLim);
    check(lastCmd == mLast, {tag, " lastCmd R9"}, lastCmd, mLast);
    check(captureStopped == modelStopped(mLim, mCnt), {tag, " stopped R6"},
          captureStopped, modelStopped(mLim, mCnt));
  endtask

  task automatic step(input logic cv, input logic [7:0] cb, input logic pv,
                      input logic [1:0] pc, input string tag);
    logic pass;
    cmdValid = cv; cmdByte = cb; pktValid = pv; pktClass = pc;
    pass = modelPass(pv, pc, mFilt, mGlob, modelStopped(mLim, mCnt));
    mFwd = pass;
    if (pass) mFwdClass = pc;
    if (cv) begin
      mLast = cb;
      if (cb >= 8'h31 && cb <= 8'h34) mFilt[cb[1:0] - 2'd1] = !mFilt[cb[1:0] - 2'd1];
      if (cb == 8'h20) mGlob = !mGlob;
      if (cb == 8'h37) mLim = mLim + 4'd1;
      if (cb == 8'h38) mLim = mLim - 4'd1;
    end
    if (cv && cb == 8'h36) mCnt = 9'd0;
    else if (pass) mCnt = mCnt + 9'd1;
    @(posedge clk); #1;
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 1'b0, 2'd0, tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    int fwdSeen;
    seedDummy = $urandom(32'd7781);
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    compareAll("R1 reset");
    rst_n = 1'b1;
    idle("R1 post-reset");

    // R2: each class toggle, then forwarding per class with global on
    for (int i = 0; i < 4; i++) step(1'b1, 8'h31 + 8'(i), 1'b0, 2'd0, "R2 toggle");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 2'(i), "R4 all filtered");
    step(1'b1, 8'h20, 1'b0, 2'd0, "R3 global off");
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, 2'(i), "R4 global off pass");
    step(1'b1, 8'h20, 1'b0, 2'd0, "R3 global on");
    step(1'b1, 8'h33, 1'b1, 2'd2, "R2 R4 same cycle");
    step(1'b0, 8'h00, 1'b1, 2'd2, "R4 data passes");

    // R5 wrap both ways
    step(1'b1, 8'h38, 1'b0, 2'd0, "R5 wrap down");
    step(1'b1, 8'h37, 1'b0, 2'd0, "R5 wrap up");
    for (int i = 0; i < 16; i++) step(1'b1, 8'h37, 1'b0, 2'd0, "R5 full cycle");

    // R9 unknown bytes
    step(1'b1, 8'h35, 1'b0, 2'd0, "R9 ignore 5");
    step(1'b1, 8'h41, 1'b0, 2'd0, "R9 ignore A");
    step(1'b1, 8'h30, 1'b0, 2'd0, "R9 ignore 0");

    // R6/R7: limit 1 -> exactly 32 forwards, then stop, then rearm
    step(1'b1, 8'h36, 1'b0, 2'd0, "R7 clear");
    for (int i = 0; i < 4; i++) if (mFilt[i]) step(1'b1, 8'h31 + 8'(i), 1'b0, 2'd0, "R2 clear filt");
    step(1'b1, 8'h37, 1'b0, 2'd0, "R5 limit 1");
    fwdSeen = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 8'h00, 1'b1, 2'(i), "R6 count");
      if (fwdValid) fwdSeen++;
    end
    check(fwdSeen == 32, "R6 forwards before stop", fwdSeen, 32);
    check(captureStopped == 1'b1, "R6 stopped", captureStopped, 1);
    step(1'b1, 8'h36, 1'b1, 2'd1, "R7 rearm with packet");
    check(captureStopped == 1'b0, "R7 released", captureStopped, 0);
    step(1'b0, 8'h00, 1'b1, 2'd3, "R7 forwards again");

    // R8: limit 0 with many packets never stops
    step(1'b1, 8'h38, 1'b0, 2'd0, "R8 limit 0");
    for (int i = 0; i < 600; i++) step(1'b0, 8'h00, 1'b1, 2'(i), "R8 continuous");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] pool [10];
      logic cv;
      pool = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h20, 8'h36, 8'h37, 8'h38, 8'h5a, 8'h39};
      cv = ($urandom % 8) == 0;
      step(cv, cv ? pool[$urandom % 10] : 8'h00, ($urandom % 4) != 0,
           2'($urandom % 4), "R4 R6 random");
    end

    rst_n = 1'b0;
    modelReset();
    @(posedge clk); #1;
    compareAll("R1 re-reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule